// File: doc/BRIEF.md
# Device Transmit Endpoint Control and Status

This block holds the control and status word for a single device-side transmit endpoint with a single-buffered FIFO. A CPU writes a 16-bit control word and reads it back through a registered read port. The block counts bytes as they are loaded into the FIFO. It declares the packet ready either on a CPU command or, in the automatic mode, when the byte count reaches the programmed maximum packet size.

On the link side, the block takes three single-cycle events: an IN token, an acknowledged packet transfer and a transmitted STALL handshake. From these it keeps the packet-ready flag, the underrun and stall status flags and the data toggle. It emits a FIFO pointer reset pulse, a one-cycle interrupt pulse, a stall-response level and a DMA request.

Top module: `txep_ctl`

## Requirements
- R1: After reset, all control and status bits, the byte count, the data toggle and the read data are 0, and `irq`, `fifo_flush`, `dma_req` and `stall_rsp` are low.
- R2: Each cycle with `byte_ld` high, while the packet is not ready and the count is below MAX_BYTES, adds one to `byte_cnt`. A load while the packet is ready, or at MAX_BYTES, leaves the count unchanged. The count returns to 0 on any event that clears the packet (R5, R6, R9).
- R3: With bit 15 (auto-ready) set, a byte load that brings `byte_cnt` equal to `max_pkt` marks the packet ready on the same clock edge. A shorter packet stays not ready until the CPU sets it.
- R4: Writing 1 to bit 0 marks the packet ready, and writing 0 to it has no effect. Bit 1 always reads the same value as bit 0.
- R5: An IN token with `pkt_acked`, or an IN token while bit 11 (force toggle) is set, counts as a completed transmission if the packet is ready. A completed transmission clears packet-ready, inverts the data toggle and raises `irq` for exactly the next cycle.
- R6: Writing 1 to bit 3 clears packet-ready, even when bit 0 is written as 1 in the same write. It also pulses `fifo_flush` and `irq` in the next cycle.
- R7: An IN token that arrives while the packet is not ready and no stall response is active sets bit 2 (underrun).
- R8: `stall_rsp` is high while bit 4 is set and bit 14 (isochronous) is clear.
- R9: A `stall_sent` event sets bit 5, clears packet-ready and the byte count, and pulses `fifo_flush` in the next cycle.
- R10: Bits 2 and 5 are cleared by a CPU write of 0 to that bit, and a write of 1 leaves them unchanged. A hardware set in the same cycle takes precedence over the clear.
- R11: Writing 1 to bit 6 forces the data toggle to 0, taking precedence over a toggle inversion in the same cycle.
- R12: With bit 12 set and the packet not ready, `dma_req` is high. In mode 0 (bit 10 clear) this holds only while `byte_cnt` is 0, and in mode 1 (bit 10 set) it holds throughout loading.
- R13: A cycle with `csr_rd` high loads `csr_rdata` with the word as it stood before that edge. Bits 15, 14, 12, 11, 10 and 4 read back as written. Bits 3 and 6, and every bit not listed, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | CPU write strobe |
| csr_wdata | input | 16 | CPU write data |
| csr_rd | input | 1 | CPU read strobe |
| csr_rdata | output | 16 | Registered read data |
| byte_ld | input | 1 | One byte written into the FIFO |
| max_pkt | input | CNT_W | Programmed maximum packet size in bytes |
| tok_in | input | 1 | IN token received |
| pkt_acked | input | 1 | Packet transmitted and acknowledged |
| stall_sent | input | 1 | STALL handshake transmitted |
| byte_cnt | output | CNT_W | Bytes currently loaded |
| fifo_flush | output | 1 | FIFO pointer reset pulse |
| data_tog | output | 1 | Current data toggle |
| irq | output | 1 | One-cycle interrupt pulse |
| dma_req | output | 1 | DMA request |
| stall_rsp | output | 1 | Endpoint answers IN tokens with STALL |

## Verification
The bench builds the block with MAX_BYTES set to 8, so `byte_cnt` is four bits wide. At that size the saturation at the count limit and an automatic ready at the full buffer size can both be reached in a few cycles. It sets `max_pkt` to values below and equal to that limit, so that the automatic ready fires both before and at the point where the count saturates. A long stretch of random events and writes then drives same-cycle collisions that directed cases alone would rarely reach: flush against set, clear against hardware set, and toggle clear against inversion.

// File: rtl/txep_pkg.sv
package txep_pkg;

  // Control word bit positions (software decodes these)
  localparam int B_AUTO   = 15;
  localparam int B_ISO    = 14;
  localparam int B_DMAEN  = 12;
  localparam int B_FRCTOG = 11;
  localparam int B_DMAMD  = 10;
  localparam int B_CLRTOG = 6;
  localparam int B_SSENT  = 5;
  localparam int B_SSTALL = 4;
  localparam int B_FLUSH  = 3;
  localparam int B_UNDER  = 2;
  localparam int B_NEMPTY = 1;
  localparam int B_RDY    = 0;

  typedef struct packed {
    logic auto_rdy;
    logic iso;
    logic dma_en;
    logic frc_tog;
    logic dma_mode;
    logic send_stall;
  } txep_cfg_t;

  function automatic txep_cfg_t cfg_from_word(input logic [15:0] w);
    txep_cfg_t c;
    c.auto_rdy   = w[B_AUTO];
    c.iso        = w[B_ISO];
    c.dma_en     = w[B_DMAEN];
    c.frc_tog    = w[B_FRCTOG];
    c.dma_mode   = w[B_DMAMD];
    c.send_stall = w[B_SSTALL];
    return c;
  endfunction

  function automatic logic [15:0] csr_view(input txep_cfg_t c, input logic sent_stall,
                                           input logic underrun, input logic rdy);
    logic [15:0] v;
    v           = '0;
    v[B_AUTO]   = c.auto_rdy;
    v[B_ISO]    = c.iso;
    v[B_DMAEN]  = c.dma_en;
    v[B_FRCTOG] = c.frc_tog;
    v[B_DMAMD]  = c.dma_mode;
    v[B_SSTALL] = c.send_stall;
    v[B_SSENT]  = sent_stall;
    v[B_UNDER]  = underrun;
    v[B_NEMPTY] = rdy;
    v[B_RDY]    = rdy;
    return v;
  endfunction

endpackage

// File: rtl/txep_bytecnt.sv
module txep_bytecnt #(
  parameter int MAX_BYTES = 1024,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             hold,
  input  logic             clr,
  input  logic             auto_rdy,
  input  logic [CNT_W-1:0] max_pkt,
  output logic [CNT_W-1:0] cnt,
  output logic             fill_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

  function automatic logic reaches(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return ({1'b0, c} + 1'b1) == {1'b0, m};
  endfunction

  logic can_ld;
  assign can_ld   = ld && !hold && (cnt != CNT_MAX);
  assign fill_hit = can_ld && auto_rdy && reaches(cnt, max_pkt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (can_ld) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txep_w0c_flag.sv
module txep_w0c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic cpu_wr,
  input  logic cpu_bit,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= 1'b0;
    else if (hw_set)            q <= 1'b1;
    else if (cpu_wr && !cpu_bit) q <= 1'b0;
  end
endmodule

// File: rtl/txep_toggle.sv
module txep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic tog
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog <= 1'b0;
    else if (clr)  tog <= 1'b0;
    else if (flip) tog <= !tog;
  end
endmodule

// File: rtl/txep_ctl.sv
module txep_ctl
  import txep_pkg::*;
#(
  parameter  int MAX_BYTES = 1024,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [15:0]      csr_wdata,
  input  logic             csr_rd,
  output logic [15:0]      csr_rdata,
  input  logic             byte_ld,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             tok_in,
  input  logic             pkt_acked,
  input  logic             stall_sent,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             fifo_flush,
  output logic             data_tog,
  output logic             irq,
  output logic             dma_req,
  output logic             stall_rsp
);
  localparam int NFLAG = 2;  // 0: underrun, 1: stall sent

  txep_cfg_t cfg_q;
  logic      pkt_rdy_q;
  logic      irq_q, flush_q;
  logic [NFLAG-1:0] flag_q, flag_set;

  // Named internal events
  logic tx_done, wr_flush, pkt_clr, pkt_set, fill_hit, ur_set;
  logic underrun_w, sent_stall_w;

  assign stall_rsp = cfg_q.send_stall && !cfg_q.iso;
  assign tx_done   = pkt_rdy_q && (pkt_acked || (cfg_q.frc_tog && tok_in));
  assign wr_flush  = csr_wr && csr_wdata[B_FLUSH];
  assign pkt_clr   = tx_done || wr_flush || stall_sent;
  assign pkt_set   = (csr_wr && csr_wdata[B_RDY]) || fill_hit;
  assign ur_set    = tok_in && !pkt_rdy_q && !stall_rsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      pkt_rdy_q <= 1'b0;
      irq_q     <= 1'b0;
      flush_q   <= 1'b0;
      csr_rdata <= '0;
    end else begin
      if (csr_wr) cfg_q <= cfg_from_word(csr_wdata);
      if (pkt_clr)      pkt_rdy_q <= 1'b0;
      else if (pkt_set) pkt_rdy_q <= 1'b1;
      irq_q   <= tx_done || wr_flush;
      flush_q <= wr_flush || stall_sent;
      if (csr_rd) csr_rdata <= csr_view(cfg_q, sent_stall_w, underrun_w, pkt_rdy_q);
    end
  end

  assign irq        = irq_q;
  assign fifo_flush = flush_q;

  txep_bytecnt #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (byte_ld),
    .hold     (pkt_rdy_q),
    .clr      (pkt_clr),
    .auto_rdy (cfg_q.auto_rdy),
    .max_pkt  (max_pkt),
    .cnt      (byte_cnt),
    .fill_hit (fill_hit)
  );

  assign flag_set[0] = ur_set;
  assign flag_set[1] = stall_sent;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int BIT = (g == 0) ? B_UNDER : B_SSENT;
    txep_w0c_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (flag_set[g]),
      .cpu_wr  (csr_wr),
      .cpu_bit (csr_wdata[BIT]),
      .q       (flag_q[g])
    );
  end

  assign underrun_w   = flag_q[0];
  assign sent_stall_w = flag_q[1];

  txep_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (csr_wr && csr_wdata[B_CLRTOG]),
    .flip  (tx_done),
    .tog   (data_tog)
  );

  assign dma_req = cfg_q.dma_en && !pkt_rdy_q && (cfg_q.dma_mode || (byte_cnt == '0));

endmodule

// File: rtl/txep_ctl_chk.sv
module txep_ctl_chk #(
  parameter int MAX_BYTES = 1024,
  parameter int CNT_W     = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_wr,
  input logic [15:0]      csr_wdata,
  input logic             tok_in,
  input logic             pkt_acked,
  input logic             stall_sent,
  input logic             pkt_rdy,
  input logic             underrun,
  input logic             ur_set,
  input logic             tx_done,
  input logic             irq,
  input logic             fifo_flush,
  input logic             data_tog,
  input logic [CNT_W-1:0] byte_cnt
);
  // R2
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(MAX_BYTES));

  // R4
  cpu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[0] && !csr_wdata[3] && !stall_sent && !tx_done) |=> pkt_rdy);

  // R5
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rdy && pkt_acked) |=> (irq && !pkt_rdy));

  // R6
  flush_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[3]) |=> (!pkt_rdy && fifo_flush && irq));

  // R7
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ur_set |=> underrun);

  // R9
  stall_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> (fifo_flush && !pkt_rdy && byte_cnt == '0));

  // R10
  w0c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_wdata[2] && !(tok_in && !pkt_rdy)) |=> !underrun);

  // R11
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[6]) |=> !data_tog);
endmodule

bind txep_ctl txep_ctl_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_wr     (csr_wr),
  .csr_wdata  (csr_wdata),
  .tok_in     (tok_in),
  .pkt_acked  (pkt_acked),
  .stall_sent (stall_sent),
  .pkt_rdy    (pkt_rdy_q),
  .underrun   (underrun_w),
  .ur_set     (ur_set),
  .tx_done    (tx_done),
  .irq        (irq),
  .fifo_flush (fifo_flush),
  .data_tog   (data_tog),
  .byte_cnt   (byte_cnt)
);

// File: tb/test_txep_ctl.sv
module test_txep_ctl;
  localparam int MAXB = 8;
  localparam int CW   = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0, csr_rd = 0, byte_ld = 0, tok_in = 0, pkt_acked = 0, stall_sent = 0;
  logic [15:0] csr_wdata = '0;
  logic [CW-1:0] max_pkt = CW'(4);
  logic [15:0] csr_rdata;
  logic [CW-1:0] byte_cnt;
  logic fifo_flush, data_tog, irq, dma_req, stall_rsp;

  always #4 clk = ~clk;

  txep_ctl #(.MAX_BYTES(MAXB)) i_txep_ctl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rd(csr_rd),
    .csr_rdata(csr_rdata), .byte_ld(byte_ld), .max_pkt(max_pkt), .tok_in(tok_in),
    .pkt_acked(pkt_acked), .stall_sent(stall_sent), .byte_cnt(byte_cnt),
    .fifo_flush(fifo_flush), .data_tog(data_tog), .irq(irq), .dma_req(dma_req),
    .stall_rsp(stall_rsp));

  int checks = 0, fails = 0;
  string scn = "R1";
  bit    cmp_on = 0;

  // Behavioural reference state
  bit m_auto, m_iso, m_dmaen, m_frc, m_dmamd, m_ss;
  bit m_rdy, m_ur, m_st, m_tog, m_irq, m_fl;
  int m_cnt;
  int m_rdata;

  function automatic int view();
    int v = 0;
    if (m_auto)  v += 32768;
    if (m_iso)   v += 16384;
    if (m_dmaen) v += 4096;
    if (m_frc)   v += 2048;
    if (m_dmamd) v += 1024;
    if (m_st)    v += 32;
    if (m_ss)    v += 16;
    if (m_ur)    v += 4;
    if (m_rdy)   v += 3;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_auto, m_iso, m_dmaen, m_frc, m_dmamd, m_ss} = '0;
      {m_rdy, m_ur, m_st, m_tog, m_irq, m_fl} = '0;
      m_cnt = 0; m_rdata = 0;
    end else begin
      bit stl, tx, wfl, clr, hit, n_rdy, n_ur, n_st, n_tog;
      int n_cnt;
      stl = m_ss && !m_iso;
      if (csr_rd) m_rdata = view();
      tx  = m_rdy && (pkt_acked || (m_frc && tok_in));
      wfl = csr_wr && csr_wdata[3];
      clr = tx || wfl || stall_sent;
      hit = m_auto && byte_ld && !m_rdy && m_cnt < MAXB && (m_cnt + 1 == int'(max_pkt));
      n_rdy = clr ? 0 : (((csr_wr && csr_wdata[0]) || hit) ? 1 : m_rdy);
      n_cnt = clr ? 0 : ((byte_ld && !m_rdy && m_cnt < MAXB) ? m_cnt + 1 : m_cnt);
      n_ur  = (tok_in && !m_rdy && !stl) ? 1 : ((csr_wr && !csr_wdata[2]) ? 0 : m_ur);
      n_st  = stall_sent ? 1 : ((csr_wr && !csr_wdata[5]) ? 0 : m_st);
      n_tog = (csr_wr && csr_wdata[6]) ? 0 : (tx ? !m_tog : m_tog);
      m_irq = tx || wfl;
      m_fl  = wfl || stall_sent;
      if (csr_wr) begin
        m_auto = csr_wdata[15]; m_iso = csr_wdata[14]; m_dmaen = csr_wdata[12];
        m_frc = csr_wdata[11]; m_dmamd = csr_wdata[10]; m_ss = csr_wdata[4];
      end
      m_rdy = n_rdy; m_cnt = n_cnt; m_ur = n_ur; m_st = n_st; m_tog = n_tog;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s (during %s): actual %0h expected %0h", req, what, scn, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2",  "byte_cnt",   int'(byte_cnt), m_cnt);
      chk("R5",  "irq",        int'(irq), int'(m_irq));
      chk("R9",  "fifo_flush", int'(fifo_flush), int'(m_fl));
      chk("R11", "data_tog",   int'(data_tog), int'(m_tog));
      chk("R12", "dma_req",    int'(dma_req), int'(m_dmaen && !m_rdy && (m_dmamd || m_cnt == 0)));
      chk("R8",  "stall_rsp",  int'(stall_rsp), int'(m_ss && !m_iso));
      chk("R13", "csr_rdata",  int'(csr_rdata), m_rdata);
    end
  end

  task automatic drv(input bit wr, input int wd, input bit rd, input bit ld,
                     input bit tk, input bit ak, input bit st);
    @(posedge clk); #2;
    csr_wr = wr; csr_wdata = 16'(wd); csr_rd = rd; byte_ld = ld;
    tok_in = tk; pkt_acked = ak; stall_sent = st;
  endtask
  task automatic idle(); drv(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input int w); drv(1, w, 0, 0, 0, 0, 0); endtask
  task automatic rdback(); drv(0, 0, 1, 0, 0, 0, 0); idle(); endtask
  task automatic load(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired during %s", scn);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "reset outputs", int'({csr_rdata, byte_cnt, fifo_flush, data_tog, irq, dma_req, stall_rsp}), 0);
    cmp_on = 1;

    scn = "R1"; rdback();
    scn = "R2"; load(3); rdback();                       // count 3, not ready
    scn = "R4"; wr(16'h0001); rdback();                 // bits 0 and 1 set
    scn = "R2"; load(2); rdback();                      // ignored while ready
    scn = "R5"; drv(0, 0, 0, 0, 1, 1, 0); idle(); rdback();
    scn = "R3"; wr(16'h8000); max_pkt = CW'(4); load(4); rdback();
    scn = "R5"; drv(0, 0, 0, 0, 1, 1, 0); idle();
    scn = "R3"; max_pkt = CW'(MAXB); load(MAXB + 2); rdback();
    scn = "R6"; drv(0, 0, 0, 0, 0, 1, 0); wr(16'h0000); load(2);
    wr(16'h0009); idle(); rdback();                      // flush with set: abort
    scn = "R2"; load(MAXB + 3); rdback();               // saturates at MAXB
    scn = "R6"; wr(16'h0008); idle();
    scn = "R7"; drv(0, 0, 0, 0, 1, 0, 0); rdback();
    scn = "R10"; wr(16'h0004); rdback();                // write 1 keeps
    drv(1, 16'h0000, 0, 0, 1, 0, 0); rdback();          // hw set wins
    wr(16'h0000); rdback();                             // write 0 clears
    scn = "R8"; wr(16'h0010); drv(0, 0, 0, 0, 1, 0, 0); rdback();
    wr(16'h4010); rdback(); drv(0, 0, 0, 0, 1, 0, 0); idle();
    scn = "R9"; load(2); wr(16'h0001); drv(0, 0, 0, 0, 0, 0, 1); idle(); rdback();
    scn = "R10"; drv(1, 16'h0000, 0, 0, 0, 0, 1); rdback(); wr(16'h0000); rdback();
    scn = "R11"; wr(16'h0001); drv(0, 0, 0, 0, 1, 1, 0); idle(); wr(16'h0040); idle();
    wr(16'h0001); drv(0, 0, 0, 0, 1, 1, 0); wr(16'h0001); drv(1, 16'h0040, 0, 0, 1, 1, 0); idle();
    scn = "R5"; wr(16'h0801); drv(0, 0, 0, 0, 1, 0, 0); idle(); rdback();
    scn = "R12"; wr(16'h1000); load(1); idle(); wr(16'h1400); load(2); idle();
    wr(16'h1401); idle(); rdback();
    scn = "R13"; wr(16'hFFFF); rdback(); wr(16'h0000); rdback();

    scn = "random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (i % 500 == 0) max_pkt = CW'($urandom_range(1, MAXB));
      drv(r < 6, int'($urandom) & 16'hDC7D | ((r < 2) ? 8 : 0), r > 90,
          r % 3 == 0, r % 7 == 0, r % 11 == 0, r == 50);
    end
    idle(); idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule